// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device holds low after an interrupted transfer. An initialisation request starts a bus check. If SCL or SDA reads low at the end of every step interval for a configurable number of steps, the sequencer takes over both open-drain outputs. It first releases both lines for one step. It then clocks out nine SCL pulses so that the stuck target can finish shifting its byte. It closes with a stop condition, pulling SDA low while SCL is high and then releasing both lines. After that the bus is checked again.

Only one recovery runs per initialisation. If the bus still reads busy on the second check, a sticky failure flag is raised. While the sequencer runs, the drives from the normal transfer engine are masked. When it is idle, those drives pass straight to the pins, so pin ownership goes back to the engine exactly as it was before. All timing comes from a step interval of `step_ticks` system clocks; about 10 µs is the intended value.

The block carries no data stream. Every port is a plain control or status level, and none has a handshake.

Top module: `i2c_bus_rescue`

## Requirements
- R1: `init_req` sampled high while `busy` is low raises `busy` on the next cycle, and `busy` stays high until the sequence ends. `init_req` sampled while `busy` is high has no effect.
- R2: A step lasts max(`step_ticks`,1) clock cycles. During a bus check, the lines are sampled in the last cycle of each step. If both `scl_in` and `sda_in` read 1, the check ends at once with `done`=1, `fail`=0 and no pulses.
- R3: The bus is declared stuck when max(`busy_limit`,1) consecutive step samples each see at least one line at 0.
- R4: On the first stuck result, both output enables are 0 for one step. Then exactly 9 SCL pulses follow. Each pulse is `scl_oe`=1 (line pulled low) for one step, then `scl_oe`=0 for one step, with `sda_oe`=0 throughout.
- R5: After the pulses, `sda_oe`=1 with `scl_oe`=0 for one step, then both are 0 for one step, and then the bus check runs again.
- R6: Only one recovery runs per initialisation. A stuck result on the second check ends the sequence with `done`=1 and `fail`=1, with no further pulses.
- R7: `done` and `fail` hold their values while idle until the next accepted `init_req`, which clears both.
- R8: While `busy` is high, `ctl_scl_oe` and `ctl_sda_oe` have no effect on the outputs. While `busy` is low, `scl_oe`=`ctl_scl_oe` and `sda_oe`=`ctl_sda_oe`.
- R9: After reset, `busy`, `done` and `fail` are 0 and the outputs follow the controller drives.
- R10: While `busy` is high, the sequencer never asserts both output enables in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Start a bus check (initialisation request) |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| step_ticks | input | TICK_W | Clock cycles per step interval (0 treated as 1) |
| busy_limit | input | LIM_W | Step samples needed to declare the bus stuck (0 treated as 1) |
| ctl_scl_oe | input | 1 | SCL pull-low request from the transfer engine |
| ctl_sda_oe | input | 1 | SDA pull-low request from the transfer engine |
| scl_oe | output | 1 | SCL open-drain enable, 1 pulls low |
| sda_oe | output | 1 | SDA open-drain enable, 1 pulls low |
| busy | output | 1 | Sequencer owns the pins |
| done | output | 1 | Sequence finished (sticky) |
| fail | output | 1 | Bus still stuck after the single recovery (sticky) |

## Verification
The bench keeps the default nine-pulse build and drives `step_ticks`=3 with `busy_limit`=2. A full recovery plus both checks then fits in under a hundred cycles, so every phase boundary is compared on every clock. An emulated target holds SDA low and lets go after a set number of SCL rising edges. This reaches both the recovered path and the two failure paths, one with SDA stuck for good and one with SCL clamped, within a short run.

// File: rtl/i2c_rescue_pkg.sv
package i2c_rescue_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CHECK,
    PH_PREP,
    PH_LOW,
    PH_HIGH,
    PH_STOP_LO,
    PH_STOP_REL
  } phase_e;
endpackage

// File: rtl/rescue_step_timer.sv
module rescue_step_timer #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TICK_W-1:0] step_ticks,
  output logic              step_end
);
  logic [TICK_W-1:0] cnt;
  logic [TICK_W-1:0] last;

  // zero is taken as a one-cycle step
  assign last     = (step_ticks == '0) ? '0 : step_ticks - 1'b1;
  assign step_end = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || step_end) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rescue_fsm.sv
module rescue_fsm
  import i2c_rescue_pkg::*;
#(
  parameter int LIM_W  = 8,
  parameter int PULSES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             step_end,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [LIM_W-1:0] busy_limit,
  output phase_e           phase,
  output logic             done,
  output logic             fail
);
  localparam int PULSE_W = $clog2(PULSES + 1);

  logic [LIM_W-1:0]   chk_cnt;
  logic [LIM_W-1:0]   chk_last;
  logic [PULSE_W-1:0] pulse_cnt;
  logic               second;
  logic               bus_free;

  assign chk_last = (busy_limit == '0) ? '0 : busy_limit - 1'b1;
  assign bus_free = scl_in && sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      chk_cnt   <= '0;
      pulse_cnt <= '0;
      second    <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (init_req) begin
          phase   <= PH_CHECK;
          chk_cnt <= '0;
          second  <= 1'b0;
          done    <= 1'b0;
          fail    <= 1'b0;
        end
        PH_CHECK: if (step_end) begin
          if (bus_free) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else if (chk_cnt == chk_last) begin
            if (second) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
              fail  <= 1'b1;
            end else begin
              phase <= PH_PREP;
            end
          end else begin
            chk_cnt <= chk_cnt + 1'b1;
          end
        end
        PH_PREP: if (step_end) begin
          phase     <= PH_LOW;
          pulse_cnt <= '0;
        end
        PH_LOW: if (step_end) phase <= PH_HIGH;
        PH_HIGH: if (step_end) begin
          if (pulse_cnt == PULSE_W'(PULSES - 1)) begin
            phase <= PH_STOP_LO;
          end else begin
            pulse_cnt <= pulse_cnt + 1'b1;
            phase     <= PH_LOW;
          end
        end
        PH_STOP_LO: if (step_end) phase <= PH_STOP_REL;
        PH_STOP_REL: if (step_end) begin
          phase   <= PH_CHECK;
          chk_cnt <= '0;
          second  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rescue_pin_mux.sv
module rescue_pin_mux (
  input  logic own,
  input  logic seq_scl,
  input  logic seq_sda,
  input  logic ctl_scl,
  input  logic ctl_sda,
  output logic scl_oe,
  output logic sda_oe
);
  assign scl_oe = own ? seq_scl : ctl_scl;
  assign sda_oe = own ? seq_sda : ctl_sda;
endmodule

// File: rtl/i2c_bus_rescue.sv
module i2c_bus_rescue
  import i2c_rescue_pkg::*;
#(
  parameter int TICK_W = 16,
  parameter int LIM_W  = 8,
  parameter int PULSES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [TICK_W-1:0] step_ticks,
  input  logic [LIM_W-1:0]  busy_limit,
  input  logic              ctl_scl_oe,
  input  logic              ctl_sda_oe,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  phase_e phase;
  logic   step_end;
  logic   seq_scl;
  logic   seq_sda;

  assign busy    = (phase != PH_IDLE);
  assign seq_scl = (phase == PH_LOW);
  assign seq_sda = (phase == PH_STOP_LO);

  rescue_step_timer #(.TICK_W(TICK_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (busy),
    .step_ticks (step_ticks),
    .step_end   (step_end)
  );

  rescue_fsm #(.LIM_W(LIM_W), .PULSES(PULSES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_req   (init_req),
    .step_end   (step_end),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .busy_limit (busy_limit),
    .phase      (phase),
    .done       (done),
    .fail       (fail)
  );

  rescue_pin_mux u_mux (
    .own     (busy),
    .seq_scl (seq_scl),
    .seq_sda (seq_sda),
    .ctl_scl (ctl_scl_oe),
    .ctl_sda (ctl_sda_oe),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe)
  );
endmodule

// File: rtl/i2c_bus_rescue_chk.sv
module i2c_bus_rescue_chk (
  input logic clk,
  input logic rst_n,
  input logic init_req,
  input logic ctl_scl_oe,
  input logic ctl_sda_oe,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic done,
  input logic fail
);
  a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && init_req) |=> busy);

  a_r1_end_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r7_fail_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !init_req) |=> ($stable(fail) && $stable(done)));

  a_r8_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_oe == ctl_scl_oe && sda_oe == ctl_sda_oe));

  a_r10_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(scl_oe && sda_oe));

  a_r1_busy_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!done && !fail));
endmodule

bind i2c_bus_rescue i2c_bus_rescue_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_req   (init_req),
  .ctl_scl_oe (ctl_scl_oe),
  .ctl_sda_oe (ctl_sda_oe),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe),
  .busy       (busy),
  .done       (done),
  .fail       (fail)
);

// File: tb/i2c_bus_rescue_test.sv
`timescale 1ns/1ps
module i2c_bus_rescue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 1'b0;
  logic [15:0] step_ticks = 16'd3;
  logic [7:0]  busy_limit = 8'd2;
  logic        ctl_scl_oe = 1'b0;
  logic        ctl_sda_oe = 1'b0;
  logic        scl_oe, sda_oe, busy, done, fail;
  logic        scl_in, sda_in;

  // emulated target and pull-ups
  logic        scl_hold = 1'b0;
  logic        sda_hold = 1'b0;
  int          rel_after = 0;
  int          rise_base = 0;
  int          rise_cnt = 0;
  logic        prev_scl = 1'b1;
  logic        sda_stuck;

  assign sda_stuck = sda_hold && (rel_after == 0 || (rise_cnt - rise_base) < rel_after);
  assign scl_in = !(scl_oe || scl_hold);
  assign sda_in = !(sda_oe || sda_stuck);

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  logic prev_oe = 1'b0;

  // reference model state
  int   m_ph = 0;
  int   m_tk = 0;
  int   m_st = 0;
  int   m_pl = 0;
  bit   m_sec = 0;
  bit   m_done = 0;
  bit   m_fail = 0;

  always #2.5 clk = ~clk;

  i2c_bus_rescue uut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .scl_in(scl_in), .sda_in(sda_in),
    .step_ticks(step_ticks), .busy_limit(busy_limit), .ctl_scl_oe(ctl_scl_oe),
    .ctl_sda_oe(ctl_sda_oe), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .done(done), .fail(fail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare, then advance the model one cycle, then update the target
  always @(negedge clk) begin
    int n, l;
    bit e_busy, e_scl, e_sda;
    if (!rst_n) begin
      m_ph = 0; m_tk = 0; m_st = 0; m_pl = 0; m_sec = 0; m_done = 0; m_fail = 0;
    end else begin
      e_busy = (m_ph != 0);
      e_scl  = e_busy ? (m_ph == 3) : ctl_scl_oe;
      e_sda  = e_busy ? (m_ph == 5) : ctl_sda_oe;
      chk(busy == e_busy, "R1 busy", busy, e_busy);
      chk(scl_oe == e_scl, "R4 scl_oe", scl_oe, e_scl);
      chk(sda_oe == e_sda, "R5 sda_oe", sda_oe, e_sda);
      chk(done == m_done, "R7 done", done, m_done);
      chk(fail == m_fail, "R6 fail", fail, m_fail);
      n = (step_ticks == 0) ? 1 : step_ticks;
      l = (busy_limit == 0) ? 1 : busy_limit;
      if (m_ph == 0) begin
        if (init_req) begin
          m_ph = 1; m_tk = 0; m_st = 0; m_sec = 0; m_done = 0; m_fail = 0;
        end
      end else if (m_tk < n - 1) begin
        m_tk++;
      end else begin
        m_tk = 0;
        case (m_ph)
          1: if (scl_in && sda_in) begin m_ph = 0; m_done = 1; end
             else if (m_st == l - 1) begin
               if (m_sec) begin m_ph = 0; m_done = 1; m_fail = 1; end
               else m_ph = 2;
             end else m_st++;
          2: begin m_ph = 3; m_pl = 0; end
          3: m_ph = 4;
          4: if (m_pl == 8) m_ph = 5; else begin m_pl++; m_ph = 3; end
          5: m_ph = 6;
          default: begin m_ph = 1; m_st = 0; m_sec = 1; end
        endcase
      end
    end
    if (busy && scl_oe && !prev_oe) pulses++;
    prev_oe = scl_oe;
    if (scl_in && !prev_scl) rise_cnt++;
    prev_scl = scl_in;
  end

  task automatic kick();
    @(posedge clk); #1 init_req = 1'b1;
    @(posedge clk); #1 init_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !fail, "R9 reset flags", {busy, done, fail}, 0);
    ctl_scl_oe = 1'b1;
    #1 chk(scl_oe == 1'b1, "R9 idle follows ctl", scl_oe, 1);
    ctl_scl_oe = 1'b0;

    // R2 free bus: one check step, no pulses
    pulses = 0;
    kick();
    #1 chk(busy == 1'b1, "R1 busy after request", busy, 1);
    wait_idle();
    chk(done && !fail, "R2 free bus done", {done, fail}, 2);
    chk(pulses == 0, "R2 no pulses on free bus", pulses, 0);

    // R4/R5 stuck SDA released after three SCL rises, masking by R8
    sda_hold = 1'b1; rel_after = 3; rise_base = rise_cnt; pulses = 0;
    kick();
    ctl_scl_oe = 1'b1; ctl_sda_oe = 1'b1;
    repeat (20) @(posedge clk);
    kick(); // R1 ignored while busy
    wait_idle();
    chk(pulses == 9, "R4 nine pulses", pulses, 9);
    chk(done && !fail, "R5 recovered after stop", {done, fail}, 2);
    #1 chk(scl_oe && sda_oe, "R8 pins back to ctl", {scl_oe, sda_oe}, 3);
    ctl_scl_oe = 1'b0; ctl_sda_oe = 1'b0;
    sda_hold = 1'b0;

    // R6 permanently stuck SDA: one recovery then fail
    sda_hold = 1'b1; rel_after = 0; pulses = 0;
    kick();
    wait_idle();
    chk(fail && done, "R6 fail after single recovery", {done, fail}, 3);
    chk(pulses == 9, "R6 only one pulse train", pulses, 9);
    repeat (10) @(posedge clk);
    #1 chk(fail == 1'b1, "R7 fail sticky", fail, 1);
    sda_hold = 1'b0;
    kick();
    #1 chk(!fail && !done, "R7 request clears flags", {done, fail}, 0);
    wait_idle();

    // R3 clamped SCL with busy_limit 0 treated as 1, step 0 treated as 1
    busy_limit = 8'd0; step_ticks = 16'd0; scl_hold = 1'b1; pulses = 0;
    kick();
    wait_idle();
    chk(fail == 1'b1, "R3 clamped SCL fails", fail, 1);
    chk(pulses == 9, "R3 pulses with unit step", pulses, 9);
    scl_hold = 1'b0; busy_limit = 8'd2; step_ticks = 16'd3;
    kick();
    wait_idle();
    chk(done && !fail, "R2 free after clamp removed", {done, fail}, 2);
    chk(!busy, "R10 idle at end", busy, 0);

    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule